// File: doc/BRIEF.md
# PWM Dead-Time Inserter

This block takes a single PWM command bit and drives the two complementary gate enables of one half-bridge. Each time the command changes level, the switch that is on is turned off at once. The switch that is about to turn on waits for a programmable dead time, so the two never conduct together. The high-side enable follows a high command, and the low-side enable follows a low one.

The dead time comes from a 4-bit code on a non-uniform scale. Codes 1 to 10 step in 50 ns increments. Codes above that step in 100 ns increments, up to 1 µs. The block converts the selected nanosecond value into whole clock cycles, rounding up, for the clock frequency given by a parameter. The code is sampled only when a transition begins. A command that reverses while a dead-time interval is running restarts the interval for the new direction.

Top module: `pwm_deadtime_gen`

## Requirements
- R1: While reset is asserted, both gate enables are low. After release, with the command low, the low-side enable is high from the first clock edge onward and the high-side enable stays low.
- R2: Codes 1 to 10 select a dead time of 50 ns times the code. The dead time in clock cycles is that value times the clock frequency divided by 10^9, rounded up. At 100 MHz, code k gives 5·k cycles.
- R3: Codes 11, 12, 13, 14 and 15 select 600, 700, 800, 900 and 1000 ns. At 100 MHz these are 60, 70, 80, 90 and 100 cycles.
- R4: On the clock edge that first samples a new command level, the enable of the side being left goes low. Both enables then stay low for exactly the dead-time cycle count. After that, the enable of the side being entered goes high.
- R5: Code 0 gives no dead time. On the edge that samples a new level, the leaving side goes low and the entering side goes high together.
- R6: If the command reverses while a dead-time count is running, the count restarts from the full value for the new direction. The value comes from the code sampled at the reversal. Both enables stay low until that new count ends, and the side abandoned mid-count never turns on.
- R7: The dead-time code is sampled only on the edge that starts a transition. Changing it during a count does not alter the length of that count.
- R8: The high-side and low-side enables are never high in the same cycle.
- R9: The high-side enable is never high in the cycle after the command is sampled low. The low-side enable is never high in the cycle after the command is sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock whose frequency is the CLK_FREQ_HZ parameter |
| rst_n | input | 1 | Active-low asynchronous reset |
| pwm_cmd | input | 1 | PWM command: 1 requests high side, 0 requests low side |
| dt_code | input | 4 | Dead-time code, 0 to 15, on the non-uniform scale |
| gate_hi | output | 1 | High-side gate enable |
| gate_lo | output | 1 | Low-side gate enable |

## Verification
A wrong internal state shows in several ways at the ports:
- A stale level register shows up one cycle after the command edge, as a leaving-side enable that failed to drop.
- A counter loaded from the wrong code, or reloaded mid-count, shows as a gap that is too long or too short. That error only appears when the entering side turns on, which can be as late as 100 cycles after the edge at 100 MHz.
- A missed restart on reversal shows as the abandoned side briefly turning on.

The gap is measured cycle by cycle for every code class, for reversals and for mid-count code changes, while overlap is watched on every cycle.

// File: rtl/pwmdt_pkg.sv
package pwmdt_pkg;

   localparam int unsigned CODE_W    = 4;
   localparam int unsigned NUM_CODES = 1 << CODE_W;
   localparam int unsigned FINE_LAST = 10;   // last code on the 50 ns grid
   localparam int unsigned FINE_NS   = 50;
   localparam int unsigned COARSE_NS = 100;
   localparam int unsigned MAX_NS    = 1000;

   // Nanoseconds selected by a code: 50 ns grid, then 100 ns grid.
   function automatic int unsigned code_to_ns(input int unsigned code);
      if (code <= FINE_LAST)
         return code * FINE_NS;
      return FINE_LAST * FINE_NS + (code - FINE_LAST) * COARSE_NS;
   endfunction

   // Nanoseconds to clock cycles, rounded up.
   function automatic int unsigned ns_to_cycles(input int unsigned ns,
                                                input int unsigned freq_hz);
      longint unsigned prod;
      prod = longint'(ns) * longint'(freq_hz) + 64'd999_999_999;
      return int'(prod / 64'd1_000_000_000);
   endfunction

endpackage

// File: rtl/pwmdt_cycle_map.sv
module pwmdt_cycle_map
   import pwmdt_pkg::*;
#(
   parameter int unsigned CLK_FREQ_HZ = 100_000_000,
   parameter int unsigned CNT_W       = 7,
   parameter bit          USE_TABLE   = 1'b1
) (
   input  logic [CODE_W-1:0] code,
   output logic [CNT_W-1:0]  cycles
);

   generate
      if (USE_TABLE) begin : g_table
         logic [CNT_W-1:0] rom [NUM_CODES];
         for (genvar g = 0; g < NUM_CODES; g++) begin : g_entry
            assign rom[g] = CNT_W'(ns_to_cycles(code_to_ns(g), CLK_FREQ_HZ));
         end
         assign cycles = rom[code];
      end else begin : g_arith
         always_comb begin
            cycles = CNT_W'(ns_to_cycles(code_to_ns(int'(code)), CLK_FREQ_HZ));
         end
      end
   endgenerate

endmodule

// File: rtl/pwmdt_timer.sv
module pwmdt_timer #(
   parameter int unsigned CNT_W = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             busy,
   output logic             expire
);

   logic [CNT_W-1:0] remain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         remain_q <= '0;
      else if (load)
         remain_q <= load_val;
      else if (remain_q != '0)
         remain_q <= remain_q - CNT_W'(1);
   end

   assign busy   = (remain_q != '0);
   assign expire = (remain_q == CNT_W'(1));

endmodule

// File: rtl/pwm_deadtime_gen.sv
module pwm_deadtime_gen
   import pwmdt_pkg::*;
#(
   parameter int unsigned CLK_FREQ_HZ = 100_000_000,
   parameter bit          USE_TABLE   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pwm_cmd,
   input  logic [CODE_W-1:0] dt_code,
   output logic              gate_hi,
   output logic              gate_lo
);

   localparam int unsigned MAX_CYC = ns_to_cycles(MAX_NS, CLK_FREQ_HZ);
   localparam int unsigned CNT_W   = (MAX_CYC < 2) ? 1 : $clog2(MAX_CYC + 1);

   generate
      if (CLK_FREQ_HZ < 1_000_000) begin : g_bad_freq
         $error("pwm_deadtime_gen: CLK_FREQ_HZ below 1 MHz");
      end
      if (MAX_CYC > 65_535) begin : g_bad_span
         $error("pwm_deadtime_gen: dead-time count exceeds 16 bits");
      end
   endgenerate

   logic [CNT_W-1:0] span_cyc;
   logic             lvl_q;
   logic             hi_q, lo_q;
   logic             flip;
   logic             t_busy, t_expire;

   assign flip = (pwm_cmd != lvl_q);

   pwmdt_cycle_map #(
      .CLK_FREQ_HZ(CLK_FREQ_HZ),
      .CNT_W      (CNT_W),
      .USE_TABLE  (USE_TABLE)
   ) u_map (
      .code  (dt_code),
      .cycles(span_cyc)
   );

   pwmdt_timer #(
      .CNT_W(CNT_W)
   ) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (flip),
      .load_val(span_cyc),
      .busy    (t_busy),
      .expire  (t_expire)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lvl_q <= 1'b0;
         hi_q  <= 1'b0;
         lo_q  <= 1'b0;
      end else if (flip) begin
         lvl_q <= pwm_cmd;
         if (span_cyc == '0) begin
            hi_q <= pwm_cmd;
            lo_q <= ~pwm_cmd;
         end else begin
            hi_q <= 1'b0;
            lo_q <= 1'b0;
         end
      end else if (t_busy) begin
         if (t_expire) begin
            hi_q <= lvl_q;
            lo_q <= ~lvl_q;
         end
      end else begin
         hi_q <= lvl_q;
         lo_q <= ~lvl_q;
      end
   end

   assign gate_hi = hi_q;
   assign gate_lo = lo_q;

endmodule

// File: rtl/pwmdt_checker.sv
module pwmdt_checker (
   input logic       clk,
   input logic       rst_n,
   input logic       pwm_cmd,
   input logic [3:0] dt_code,
   input logic       gate_hi,
   input logic       gate_lo
);

   p_no_overlap_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !(gate_hi && gate_lo));

   p_hi_off_at_once_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(pwm_cmd) |-> !gate_hi);

   p_lo_off_at_once_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $past(pwm_cmd) |-> !gate_lo);

   p_direct_handover_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(gate_hi) && $past(gate_lo)) |-> ($past(dt_code) == 4'd0));

   p_hi_follows_cmd_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(gate_hi) |-> $past(pwm_cmd));

endmodule

bind pwm_deadtime_gen pwmdt_checker u_pwmdt_checker (
   .clk    (clk),
   .rst_n  (rst_n),
   .pwm_cmd(pwm_cmd),
   .dt_code(dt_code),
   .gate_hi(gate_hi),
   .gate_lo(gate_lo)
);

// File: tb/pwm_deadtime_gen_test.sv
module pwm_deadtime_gen_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       pwm_cmd = 1'b0;
   logic [3:0] dt_code = 4'd0;
   logic       gate_hi, gate_lo;

   int n_checks = 0;
   int n_fail   = 0;
   int overlap_seen = 0;
   bit reported = 1'b0;

   always #5ns clk = ~clk;

   pwm_deadtime_gen uut (
      .clk    (clk),
      .rst_n  (rst_n),
      .pwm_cmd(pwm_cmd),
      .dt_code(dt_code),
      .gate_hi(gate_hi),
      .gate_lo(gate_lo)
   );

   always @(negedge clk) if (rst_n && gate_hi && gate_lo) overlap_seen++;

   function automatic int exp_cycles(input int code);
      int ns;
      ns = (code <= 10) ? code * 50 : 500 + (code - 10) * 100;
      return (ns + 9) / 10;   // 10 ns clock period, rounded up
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic report;
      if (!reported) begin
         reported = 1'b1;
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      end
      $finish;
   endtask

   // Drive a new level at a negedge, count cycles with both off until target side is on.
   task automatic transition(input logic lvl, output int gap, output bit leave_late);
      pwm_cmd = lvl;
      gap = 0;
      leave_late = 1'b0;
      for (int i = 0; i < 400; i++) begin
         @(negedge clk);
         if (i == 0 && (lvl ? gate_lo : gate_hi)) leave_late = 1'b1;
         if (lvl ? gate_hi : gate_lo) break;
         if (!gate_hi && !gate_lo) gap++;
      end
   endtask

   task automatic t_reset;
      @(negedge clk);
      check(!gate_hi && !gate_lo, "R1 reset both off", {gate_hi, gate_lo}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(gate_lo && !gate_hi, "R1 low side after release", {gate_hi, gate_lo}, 1);
   endtask

   task automatic t_code(input int code, input string req);
      int gap; bit late;
      dt_code = 4'(code);
      transition(1'b1, gap, late);
      check(gap == exp_cycles(code) && gate_hi, {req, " rise gap"}, gap, exp_cycles(code));
      check(!late, "R4 low side off at once", late, 0);
      transition(1'b0, gap, late);
      check(gap == exp_cycles(code) && gate_lo, {req, " fall gap"}, gap, exp_cycles(code));
      check(!late, "R4 high side off at once", late, 0);
   endtask

   task automatic t_zero;
      int gap; bit late;
      dt_code = 4'd0;
      transition(1'b1, gap, late);
      check(gap == 0 && gate_hi && !gate_lo, "R5 code 0 rise direct", gap, 0);
      transition(1'b0, gap, late);
      check(gap == 0 && gate_lo && !gate_hi, "R5 code 0 fall direct", gap, 0);
   endtask

   task automatic t_reverse;
      int gap; bit late; bit hi_seen;
      hi_seen = 1'b0;
      dt_code = 4'd10;
      pwm_cmd = 1'b1;
      for (int i = 0; i < 20; i++) begin
         @(negedge clk);
         if (gate_hi || gate_lo) hi_seen = 1'b1;
      end
      dt_code = 4'd3;
      pwm_cmd = 1'b0;
      gap = 0;
      for (int i = 0; i < 200; i++) begin
         @(negedge clk);
         if (gate_hi) hi_seen = 1'b1;
         if (gate_lo) break;
         gap++;
      end
      check(!hi_seen, "R6 abandoned side never on", hi_seen, 0);
      check(gap == exp_cycles(3), "R6 restart with new count", gap, exp_cycles(3));
   endtask

   task automatic t_midchange;
      int gap;
      dt_code = 4'd15;
      pwm_cmd = 1'b1;
      gap = 0;
      for (int i = 0; i < 400; i++) begin
         @(negedge clk);
         if (i == 10) dt_code = 4'd1;
         if (gate_hi) break;
         gap++;
      end
      check(gap == exp_cycles(15), "R7 code change mid-count ignored", gap, exp_cycles(15));
      pwm_cmd = 1'b0;
      for (int i = 0; i < 20; i++) @(negedge clk);
      check(gate_lo, "R7 next transition uses new code", gate_lo, 1);
   endtask

   initial begin
      #2ms;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
   end

   initial begin
      t_reset();
      t_code(1, "R2 code 1");
      t_code(5, "R2 code 5");
      t_code(10, "R2 code 10");
      t_code(11, "R3 code 11");
      t_code(13, "R3 code 13");
      t_code(15, "R3 code 15");
      t_zero();
      t_reverse();
      t_midchange();
      check(overlap_seen == 0, "R8 no overlap", overlap_seen, 0);
      report();
   end

endmodule